// File: doc/BRIEF.md
# Full-Palette Color Sweep Pixel Source

This block supplies 12-bit pixel words to a raster timing controller that runs in the same 100 MHz clock domain. The controller raises a request line for every active pixel it wants filled, and it pulses an end-of-frame line once per frame. The block answers each request with the color assigned to the current frame. When no request is active, it drives black.

A 12-bit frame color register starts at zero after reset. It advances by one on every end-of-frame pulse and wraps from 4095 back to 0. Over 4096 consecutive frames the display therefore shows every color that a 4-bit-per-channel word can express, one solid color per frame. The output is registered, so a pixel appears one clock after the request that asked for it.

Top module: `cpg_palette_sweep`

## Requirements
- R1: While `rst_n` is low, `rgb_o` is 0 and the frame color is 0. The first pixel requested after reset, before any end-of-frame pulse, is 0x000.
- R2: The pixel word packs red in bits 11:8, green in bits 7:4 and blue in bits 3:0. Read as an unsigned number, it equals the frame color value.
- R3: When `pix_req_i` is high at a rising edge, `rgb_o` carries the current frame color from that edge until the next one.
- R4: When `pix_req_i` is low at a rising edge, `rgb_o` is 0x000 from that edge until the next one.
- R5: Each rising edge with `frame_end_i` high raises the frame color by exactly one.
- R6: A frame color of 4095 becomes 0 on the next end-of-frame pulse.
- R7: When `pix_req_i` and `frame_end_i` are both high at the same edge, the pixel produced at that edge carries the frame color from before the increment.
- R8: With no end-of-frame pulse, the frame color does not change, so every pixel requested within one frame carries the same color.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_req_i | input | 1 | The controller requests a pixel for this cycle |
| frame_end_i | input | 1 | Single-cycle end-of-frame pulse |
| rgb_o | output | 12 | Registered pixel word {red, green, blue} |

## Verification
Two functions can fall in the same cycle: a pixel request and the frame color increment. They meet when the controller pulses end-of-frame while the request line is still high. The bench provokes this case with a directed pair of pulses and with many random cycles in which both lines are high. Its model gives that pixel the color from before the increment, and it gives the pixel one cycle later the new color.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
  localparam int unsigned CH_W    = 4;
  localparam int unsigned COLOR_W = 3 * CH_W;

  typedef logic [CH_W-1:0]    chan_t;
  typedef logic [COLOR_W-1:0] color_t;

  typedef struct packed {
    chan_t red;
    chan_t grn;
    chan_t blu;
  } rgb_t;

  function automatic color_t next_color(input color_t c);
    return (c == {COLOR_W{1'b1}}) ? '0 : c + color_t'(1);
  endfunction

  function automatic rgb_t unpack_color(input color_t c);
    rgb_t p;
    p.red = c[3*CH_W-1:2*CH_W];
    p.grn = c[2*CH_W-1:CH_W];
    p.blu = c[CH_W-1:0];
    return p;
  endfunction
endpackage

// File: rtl/cpg_frame_counter.sv
module cpg_frame_counter
  import cpg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   advance_i,
  output color_t color_o
);
  color_t color_q;
  logic   at_top;

  assign at_top = (color_q == {COLOR_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          color_q <= '0;
    else if (advance_i)  color_q <= next_color(color_q);
  end

  assign color_o = color_q;

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !at_top) |=> (color_q == $past(color_q) + color_t'(1)));
  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && at_top) |=> (color_q == '0));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !advance_i |=> $stable(color_q));
endmodule

// File: rtl/cpg_pixel_stage.sv
module cpg_pixel_stage
  import cpg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   fill_i,
  input  color_t color_i,
  output rgb_t   pix_o
);
  rgb_t pix_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pix_q <= '0;
    else if (fill_i) pix_q <= unpack_color(color_i);
    else             pix_q <= '0;
  end

  assign pix_o = pix_q;

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_i |=> (pix_q == '0));
endmodule

// File: rtl/cpg_palette_sweep.sv
module cpg_palette_sweep
  import cpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_req_i,
  input  logic              frame_end_i,
  output logic [COLOR_W-1:0] rgb_o
);
  logic   advance_ev;
  logic   fill_ev;
  color_t frame_color;
  rgb_t   pix;

  assign advance_ev = frame_end_i;
  assign fill_ev    = pix_req_i;

  cpg_frame_counter u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance_i (advance_ev),
    .color_o   (frame_color)
  );

  cpg_pixel_stage u_pixel (
    .clk     (clk),
    .rst_n   (rst_n),
    .fill_i  (fill_ev),
    .color_i (frame_color),
    .pix_o   (pix)
  );

  assign rgb_o = {pix.red, pix.grn, pix.blu};

  assert_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ev |=> (rgb_o == $past(frame_color)));
  assert_collide_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_ev && advance_ev) |=> (rgb_o != frame_color));
  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |-> (rgb_o == '0 && frame_color == '0));
endmodule

// File: tb/cpg_palette_sweep_tb.sv
module cpg_palette_sweep_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        fe = 1'b0;
  logic [11:0] rgb;

  int checks = 0;
  int errors = 0;
  int model  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpg_palette_sweep u_dut (
    .clk (clk), .rst_n (rst_n), .pix_req_i (req),
    .frame_end_i (fe), .rgb_o (rgb)
  );

  function automatic int exp_pixel(input int color, input bit r);
    return r ? color : 0;
  endfunction

  function automatic int bump(input int color, input bit f);
    return f ? (color + 1) % 4096 : color;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %03h expected %03h", tag, got, exp);
    end
  endtask

  // Drive at a negedge, let one rising edge pass, sample at the next negedge.
  task automatic cyc(input bit r, input bit f, input string tag);
    int e;
    req = r; fe = f;
    e = exp_pixel(model, r);
    model = bump(model, f);
    @(negedge clk);
    check(tag, int'(rgb), e);
  endtask

  task automatic auto_cyc(input bit r, input bit f);
    if (r && f)  cyc(r, f, "R7");
    else if (r)  cyc(r, f, "R3");
    else         cyc(r, f, "R4");
  endtask

  task automatic fields(input int v);
    cyc(1'b1, 1'b0, "R2");
    check("R2 red",   int'(rgb[11:8]), (v / 256) % 16);
    check("R2 green", int'(rgb[7:4]),  (v / 16) % 16);
    check("R2 blue",  int'(rgb[3:0]),  v % 16);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    req = 1'b1; fe = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset output", int'(rgb), 0);
    req = 1'b0; fe = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b1, 1'b0, "R1 first pixel");
    cyc(1'b0, 1'b0, "R4 idle");
    // Same color across a frame: R8
    repeat (5) cyc(1'b1, 1'b0, "R8 frame hold");
    cyc(1'b0, 1'b1, "R5 advance");
    cyc(1'b1, 1'b0, "R5 new color");
    // Collision directed: R7
    cyc(1'b1, 1'b1, "R7 collide old color");
    cyc(1'b1, 1'b0, "R7 next shows new");
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      auto_cyc(($urandom % 4) != 0, ($urandom % 8) == 0);
    end
    fields(model);
    // Reach 0x5A3 and 0xFFF, check fields, then the wrap
    while (model != 12'h5A3) cyc(1'b0, 1'b1, "R5 walk");
    fields(model);
    while (model != 4095) cyc(($urandom % 2) == 1, 1'b1, "R5 walk");
    fields(model);
    cyc(1'b0, 1'b1, "R6 wrap edge");
    cyc(1'b1, 1'b0, "R6 wrapped to zero");
    // Full sweep with collisions every cycle: every color appears
    for (int i = 0; i < 4100; i++) cyc(1'b1, 1'b1, "R7 sweep");
    // Mid-run reset
    req = 1'b1; fe = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", int'(rgb), 0);
    @(negedge clk);
    rst_n = 1'b1;
    model = 0;
    cyc(1'b1, 1'b0, "R1 color after reset");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule